// File: doc/BRIEF.md
# Two-Phase Handshake Storage Chain

This block is a first-in first-out queue built as a linear chain of storage stages. Words move between neighbouring stages under a two-phase bundled-data protocol. A sender announces a new word by flipping its request wire, and the receiver confirms it by flipping its acknowledge wire. Either direction of a flip counts as one event, so no return-to-zero phase is needed. The same protocol is used at the producer side and at the consumer side.

Each stage keeps a single toggle bit that acts as a Muller C-element. The bit flips when the stage on its left offers a new word and the stage on its right has already taken the previous one. In that case the stage captures the word in the same cycle. Inside the chain the model advances one stage per cycle of a system clock. Both external wires that enter the block, the producer's request and the consumer's acknowledge, are registered before use. A word therefore flows forward without further stimulus until it is shown at the output or stops behind the last occupied stage.

The producer may flip its request only after its previous request has been acknowledged. It must hold the data bus steady until that acknowledge arrives. The consumer reads the output bus while the output request differs from its own acknowledge level, and flips its acknowledge to release the word.

Top module: `toggle_fifo`

## Requirements
- R1: While rst_n is low and after it is released, ack_in and req_out are low and every stage is empty. A pending request is flagged when req_out differs from ack_out.
- R2: A rising flip and a falling flip of req_in each admit exactly one word, and each produces exactly one flip of ack_in.
- R3: When the first stage is empty, ack_in flips on the second rising clock edge after req_in flips.
- R4: A word entered into an empty chain appears at the output with a req_out flip on rising edge DEPTH+1 after req_in flips, and not earlier. This happens with no further input activity.
- R5: While req_out differs from ack_out, req_out and data_out stay unchanged, however long the consumer waits.
- R6: With DEPTH words stored and ack_out not flipped, a further req_in flip receives no ack_in flip.
- R7: When the chain is full, one ack_out flip frees room, and the waiting request is then acknowledged.
- R8: Words leave in the order they entered, with their values unchanged.
- R9: A stage's toggle bit changes only when its left request differs from it and its right acknowledge equals it. The stage's data changes only in the same cycle.
- R10: The producer and consumer sides run independently. Any mix of producer and consumer pacing delivers every word once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the synchronous model |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | 1 | Producer request; each flip offers a word |
| data_in | input | WIDTH | Producer data, held while its request is unacknowledged |
| ack_in | output | 1 | Acknowledge to producer; each flip confirms a word taken |
| req_out | output | 1 | Consumer request; each flip presents a word |
| data_out | output | WIDTH | Word presented to the consumer |
| ack_out | input | 1 | Consumer acknowledge; each flip releases the presented word |

## Verification
The assertions assume that both neighbours keep to the two-phase rules. The producer flips req_in only when it equals ack_in, and keeps data_in steady until ack_in catches up. The consumer flips ack_out only while it differs from req_out. The bench's producer and consumer tasks wait for exactly those conditions at a falling clock edge before driving anything. As a result, no stimulus ever offers a second word over an unacknowledged one or releases a word that was never presented.

// File: rtl/toggle_fifo_pkg.sv
// Package: helpers shared by the two-phase storage chain.
// Assumes: handshake wires carry levels, and a level change is one event.
package toggle_fifo_pkg;

    // True when a wire's current level differs from a reference level.
    function automatic logic tog_event(input logic now_lvl, input logic ref_lvl);
        return now_lvl ^ ref_lvl;
    endfunction

endpackage

// File: rtl/tfifo_sampler.sv
// Module: tfifo_sampler
// Registers one external handshake wire into the clock domain of the chain.
// Assumes: the wire changes at most once per handshake, and the partner holds
// it until the answering flip is returned.
module tfifo_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic wire_i,
    output logic level_o
);

    logic level_q;

    // Capture the external level once per clock; it is low after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= wire_i;
        end
    end

    assign level_o = level_q;

endmodule

// File: rtl/tfifo_stage.sv
// Module: tfifo_stage
// One storage stage. Its toggle bit acts as a C-element whose inputs are the
// left request and the inverted right acknowledge. The bit serves as both the
// acknowledge to the left and the request to the right.
// Assumes: the left data is stable while req_l differs from tog_o.
module tfifo_stage
    import toggle_fifo_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_l,
    input  logic [WIDTH-1:0] data_l,
    input  logic             ack_r,
    output logic             tog_o,
    output logic [WIDTH-1:0] data_o
);

    logic             tog_q;
    logic [WIDTH-1:0] data_q;
    logic             offer;
    logic             room;
    logic             fire;

    // A new word is offered on the left, and the right has taken the last one.
    always_comb begin
        offer = tog_event(req_l, tog_q);
        room  = !tog_event(ack_r, tog_q);
        fire  = offer && room;
    end

    // Flip the toggle bit and capture the word together when both inputs agree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q  <= 1'b0;
            data_q <= '0;
        end else if (fire) begin
            tog_q  <= ~tog_q;
            data_q <= data_l;
        end
    end

    assign tog_o  = tog_q;
    assign data_o = data_q;

    // R9
    no_fire_without_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_l == tog_q) |=> ($stable(tog_q) && $stable(data_q)));

    // R9
    no_fire_without_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_r != tog_q) |=> ($stable(tog_q) && $stable(data_q)));

endmodule

// File: rtl/toggle_fifo.sv
// Module: toggle_fifo
// A first-in first-out chain of DEPTH stages that uses two-phase handshakes at
// both ends. req_in and ack_out are registered once on entry. Stage i takes its
// request from stage i-1, or from the registered req_in, and its acknowledge
// from stage i+1, or from the registered ack_out.
// Assumes: both neighbours keep to the two-phase protocol (see the brief).
module toggle_fifo
    import toggle_fifo_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_in,
    input  logic [WIDTH-1:0] data_in,
    output logic             ack_in,
    output logic             req_out,
    output logic [WIDTH-1:0] data_out,
    input  logic             ack_out
);

    localparam int unsigned LAST = DEPTH - 1;

    logic             req_s;
    logic             ack_s;
    logic             tog   [DEPTH];
    logic [WIDTH-1:0] word  [DEPTH];

    tfifo_sampler i_req_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .wire_i  (req_in),
        .level_o (req_s)
    );

    tfifo_sampler i_ack_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .wire_i  (ack_out),
        .level_o (ack_s)
    );

    // Chain of stages; the first and last stages connect to the sampled ports.
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic             req_left;
        logic [WIDTH-1:0] data_left;
        logic             ack_right;

        if (i == 0) begin : g_head
            assign req_left  = req_s;
            assign data_left = data_in;
        end else begin : g_body
            assign req_left  = tog[i-1];
            assign data_left = word[i-1];
        end

        if (i == LAST) begin : g_tail
            assign ack_right = ack_s;
        end else begin : g_inner
            assign ack_right = tog[i+1];
        end

        tfifo_stage #(.WIDTH(WIDTH)) i_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_l  (req_left),
            .data_l (data_left),
            .ack_r  (ack_right),
            .tog_o  (tog[i]),
            .data_o (word[i])
        );
    end

    assign ack_in   = tog[0];
    assign req_out  = tog[LAST];
    assign data_out = word[LAST];

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out != ack_s) |=> ($stable(req_out) && $stable(data_out)));

    // R2
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_s == ack_in) |=> $stable(ack_in));

    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> (!ack_in && !req_out));

endmodule

// File: tb/test_toggle_fifo.sv
module test_toggle_fifo;

    localparam int unsigned WIDTH = 8;
    localparam int unsigned DEPTH = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_in = 1'b0;
    logic [WIDTH-1:0] data_in = '0;
    logic             ack_in;
    logic             req_out;
    logic [WIDTH-1:0] data_out;
    logic             ack_out = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    toggle_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_toggle_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (req_in),
        .data_in  (data_in),
        .ack_in   (ack_in),
        .req_out  (req_out),
        .data_out (data_out),
        .ack_out  (ack_out)
    );

    always #4 clk = ~clk;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Producer: wait until the previous word is acknowledged, then offer a new one.
    task automatic push(input logic [WIDTH-1:0] w);
        while (ack_in != req_in) @(negedge clk);
        data_in = w;
        req_in  = ~req_in;
    endtask

    // Consumer: wait for a presented word, compare it, release it.
    task automatic pop(input logic [WIDTH-1:0] w, input string tag);
        while (req_out == ack_out) @(negedge clk);
        check(data_out == w, tag, int'(data_out), int'(w));
        ack_out = ~ack_out;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(ack_in == 1'b0, "R1 ack_in", int'(ack_in), 0);
        check(req_out == 1'b0, "R1 req_out", int'(req_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_out == ack_out, "R1 empty", int'(req_out), int'(ack_out));

        // R3 and R4: latency through an empty chain, rising request
        data_in = 8'hA5;
        req_in  = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(ack_in == 1'b1, "R3 ack_in after two edges", int'(ack_in), 1);
        repeat (DEPTH - 2) @(posedge clk);
        @(negedge clk);
        check(req_out == 1'b0, "R4 req_out not early", int'(req_out), 0);
        @(posedge clk);
        @(negedge clk);
        check(req_out == 1'b1, "R4 req_out at DEPTH+1", int'(req_out), 1);
        check(data_out == 8'hA5, "R4 data", int'(data_out), 8'hA5);

        // R5: the consumer stalls; output is held
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check(req_out == 1'b1 && data_out == 8'hA5, "R5 hold", int'(data_out), 8'hA5);
        end
        ack_out = 1'b1;
        @(negedge clk);

        // R2: a falling request is also one event
        push(8'h3C);
        check(req_in == 1'b0, "R2 falling request issued", int'(req_in), 0);
        pop(8'h3C, "R2 falling request word");
        repeat (3) @(negedge clk);
        check(ack_in == 1'b0 && req_out == 1'b0, "R2 one ack per request", int'(ack_in), 0);

        // R6, R7, R8, R9: fill the chain, then offer one more word
        for (int k = 0; k < DEPTH; k++) push(8'(8'h10 + k));
        push(8'h77);
        repeat (30) @(negedge clk);
        check(ack_in != req_in, "R6 no ack when full (R9 no room)", int'(ack_in), int'(~req_in));
        check(req_out != ack_out && data_out == 8'h10, "R6 head word", int'(data_out), 8'h10);
        ack_out = ~ack_out;
        repeat (DEPTH + 3) @(negedge clk);
        check(ack_in == req_in, "R7 ack after room freed", int'(ack_in), int'(req_in));
        for (int k = 1; k < DEPTH; k++) pop(8'(8'h10 + k), "R8 order after fill");
        pop(8'h77, "R8 late word");

        // R10 and R8: sweep producer and consumer pacing
        for (int pg = 0; pg < 3; pg++) begin
            for (int cg = 0; cg < 3; cg++) begin
                fork
                    begin
                        for (int k = 0; k < 24; k++) begin
                            repeat (pg * 2) @(negedge clk);
                            push(8'((k * 37 + pg * 5 + cg) & 8'hFF));
                        end
                    end
                    begin
                        for (int k = 0; k < 24; k++) begin
                            repeat (cg * 3) @(negedge clk);
                            pop(8'((k * 37 + pg * 5 + cg) & 8'hFF), "R10 paced stream");
                        end
                    end
                join
            end
        end
        repeat (DEPTH + 4) @(negedge clk);
        check(req_out == ack_out && ack_in == req_in, "R10 drained", int'(req_out), int'(ack_out));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule